// File: doc/BRIEF.md
# Pressure Sensor SPI Readout Emulator

This block stands in for the digital face of an amplified pressure sensor. A free-running interval timer copies a corrected sample from a parallel input into an internal holding register at a fixed period. The timer runs whether or not the bus is busy. An SPI master reads the most recent value with a fixed 24-bit frame. The frame opens with a filler byte of all ones. A padding bit follows, and then the pressure as a 15-bit word, most significant bit first. The 14-bit sample fills the low bits of that word, and the top pressure bit is always zero.

The SPI pins are sampled by the system clock through synchronizers, so the SPI clock must be much slower than the system clock. Two static inputs select the clock polarity and phase, which gives all four SPI modes. The mode with both set to zero is the expected default. When the select line falls, the block captures the holding register into a frame register. This capture means a refresh that arrives during a transfer cannot split the word. Raising select before the frame ends abandons it, and the next read starts again at the filler byte. While the block is not selected, an output-enable signal stays low and MISO idles high. MOSI is accepted but never used.

Top module: `pressure_spi_emu`

## Requirements
- R1: While reset is asserted, `spi_miso_oe` is 0 and `spi_miso` is 1.
- R2: The holding register changes only when the interval counter wraps, which happens once every `UPDATE_CYCLES` system clocks. It resets to 0. A read started before the first wrap returns pressure 0, and a read started after a wrap returns the `sample_in` value present at that wrap. SPI activity has no effect on this timing.
- R3: The first 8 bits shifted out in every frame are all ones (0xFF).
- R4: Frame bits 9 to 24 are, in order: a padding bit equal to 0, a pressure bit 14 equal to 0, then `sample_in` bits 13 down to 0. So the 24-bit frame equals {8'hFF, 2'b00, sample}.
- R5: The frame content is captured when select falls. A holding-register refresh or a `sample_in` change during the transfer does not alter the bits that are shifted out.
- R6: With `cfg_cpha`=0, each bit is valid before the leading SCK edge, and MISO advances on the trailing edge. With `cfg_cpha`=1, MISO advances on each leading edge after the first, and the master samples on the trailing edge. `cfg_cpol` gives the SCK idle level (0 or 1). The leading edge is the one that leaves the idle level.
- R7: If select rises before 24 bits have been sent, the frame is abandoned. The next select fall starts a new frame from bit 1 (the filler byte).
- R8: `spi_miso_oe` is 1 while select is held low and 0 while it is high, each within a few system clocks. MISO is 1 whenever `spi_miso_oe` is 0.
- R9: Once all 24 bits have been sent, further SCK edges in the same frame shift out ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sample_in | input | SAMPLE_W | Corrected sample offered to the interval timer |
| spi_sck | input | 1 | SPI clock from master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Master output (ignored) |
| spi_miso | output | 1 | Slave serial data out |
| spi_miso_oe | output | 1 | High while MISO should be driven onto the bus |

## Verification
The assertions assume that every SCK and select level lasts at least three system clocks. They also assume that select only changes while SCK is at its idle level, and that the mode inputs only change while select is high. The bench holds each SCK half-period for eight system clocks. It waits eight clocks between select edges and the nearest SCK edge, and it changes the mode only between frames. Within those limits, a captured frame stays fixed until the next select fall, and the bit pointer never passes the frame length.

// File: rtl/pse_pkg.sv
package pse_pkg;
    localparam int FILL_BITS  = 8;
    localparam int PRESS_W    = 15;
    localparam int FRAME_BITS = FILL_BITS + 1 + PRESS_W;
    localparam int PTR_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic                  active;
        logic                  started;
        logic [PTR_W-1:0]      ptr;
        logic [FRAME_BITS-1:0] frame;
        logic                  miso;
        logic                  oe;
    } shift_st_t;
endpackage

// File: rtl/pse_sync_edge.sv
module pse_sync_edge #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
        logic              prev;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d      = q;
        d.sr   = {q.sr[STAGES-2:0], async_in};
        d.prev = q.sr[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sr   <= {STAGES{RESET_VAL}};
            q.prev <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign level = q.sr[STAGES-1];
    assign rise  = level & ~q.prev;
    assign fall  = ~level & q.prev;
endmodule

// File: rtl/pse_update_timer.sv
module pse_update_timer #(
    parameter int SAMPLE_W      = 14,
    parameter int UPDATE_CYCLES = 25000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] held_sample
);
    localparam int CNT_W = $clog2(UPDATE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPDATE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] sample;
    } tmr_st_t;

    tmr_st_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == LAST) begin
            d.cnt    = '0;
            d.sample = sample_in;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign held_sample = q.sample;

    a_r2_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != LAST) |=> $stable(q.sample));
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);
endmodule

// File: rtl/pse_frame_shifter.sv
module pse_frame_shifter
    import pse_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpol,
    input  logic                  cpha,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  ss_level,
    input  logic                  ss_fall,
    input  logic [FRAME_BITS-1:0] frame_in,
    output logic                  miso,
    output logic                  oe
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(FRAME_BITS);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(FRAME_BITS - 1);

    shift_st_t q, d;
    logic lead, trail;

    always_comb begin
        lead  = cpol ? sck_fall : sck_rise;
        trail = cpol ? sck_rise : sck_fall;
        d     = q;
        if (ss_fall) begin
            d.active  = 1'b1;
            d.started = 1'b0;
            d.ptr     = '0;
            d.frame   = frame_in;
        end else if (ss_level) begin
            d.active  = 1'b0;
            d.started = 1'b0;
            d.ptr     = '0;
        end else if (q.active) begin
            if (cpha) begin
                if (lead) begin
                    if (!q.started)         d.started = 1'b1;
                    else if (q.ptr < PTR_END) d.ptr   = q.ptr + 1'b1;
                end
            end else if (trail && q.ptr < PTR_END) begin
                d.ptr = q.ptr + 1'b1;
            end
        end
        d.oe   = d.active;
        d.miso = (!d.active || d.ptr >= PTR_END) ? 1'b1 : d.frame[PTR_TOP - d.ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.miso <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;
    assign oe   = q.oe;

    a_r7_restart_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> (q.active && q.ptr == '0));
    a_r3_fill_leads: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> q.miso);
    a_r5_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !ss_fall) |=> $stable(q.frame));
    a_r9_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.ptr <= PTR_END);
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe |-> q.miso);
    a_r8_released_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_level && !ss_fall) |=> !q.oe);
endmodule

// File: rtl/pressure_spi_emu.sv
module pressure_spi_emu
    import pse_pkg::*;
#(
    parameter int SAMPLE_W      = 14,
    parameter int UPDATE_CYCLES = 25000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                spi_sck,
    input  logic                spi_ss_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                spi_miso_oe
);
    logic [SAMPLE_W-1:0]   held;
    logic [FRAME_BITS-1:0] frame;
    logic sck_lvl, sck_rise, sck_fall;
    logic ss_lvl, ss_rise, ss_fall;
    logic unused_in;

    assign unused_in = spi_mosi ^ sck_lvl ^ ss_rise;

    pse_update_timer #(
        .SAMPLE_W     (SAMPLE_W),
        .UPDATE_CYCLES(UPDATE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .held_sample(held)
    );

    pse_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .async_in(spi_sck),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    pse_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .async_in(spi_ss_n),
        .level(ss_lvl), .rise(ss_rise), .fall(ss_fall)
    );

    assign frame = {{FILL_BITS{1'b1}}, 1'b0, PRESS_W'(held)};

    pse_frame_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpol    (cfg_cpol),
        .cpha    (cfg_cpha),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .ss_level(ss_lvl),
        .ss_fall (ss_fall),
        .frame_in(frame),
        .miso    (spi_miso),
        .oe      (spi_miso_oe)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!spi_miso_oe && spi_miso));
endmodule

// File: tb/sim_pressure_spi_emu.sv
module sim_pressure_spi_emu;
    localparam int PERIOD = 1000;
    localparam int HALF   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [13:0] sample_in = 14'h1234;
    logic        spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b1;
    logic        spi_miso, spi_miso_oe;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;
    logic [31:0] rx;

    always #10 clk = ~clk;

    pressure_spi_emu #(.SAMPLE_W(14), .UPDATE_CYCLES(PERIOD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .sample_in(sample_in), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] frame_of(input logic [13:0] s);
        return {8'hFF, 2'b00, s};
    endfunction

    task automatic xfer(input logic cpol, input logic cpha, input int nbits,
                        input logic do_stall, input logic [13:0] stall_val,
                        output logic [31:0] data);
        data = '0;
        @(negedge clk);
        cfg_cpol = cpol; cfg_cpha = cpha; spi_sck = cpol;
        tick(HALF);
        spi_ss_n = 1'b0;
        tick(HALF);
        check("R8 oe while selected", {31'd0, spi_miso_oe}, 32'd1);
        for (int i = 0; i < nbits; i++) begin
            if (do_stall && i == 8) begin
                sample_in = stall_val;
                tick(PERIOD + 100);
            end
            if (!cpha) begin
                data = {data[30:0], spi_miso};
                spi_sck = ~cpol;
                tick(HALF);
                spi_sck = cpol;
                tick(HALF);
            end else begin
                spi_sck = ~cpol;
                tick(HALF);
                data = {data[30:0], spi_miso};
                spi_sck = cpol;
                tick(HALF);
            end
        end
        spi_ss_n = 1'b1;
        tick(HALF);
        check("R8 oe released", {31'd0, spi_miso_oe}, 32'd0);
        check("R8 idle high", {31'd0, spi_miso}, 32'd1);
    endtask

    task automatic t_reset;
        tick(3);
        check("R1 oe in reset", {31'd0, spi_miso_oe}, 32'd0);
        check("R1 miso in reset", {31'd0, spi_miso}, 32'd1);
        rst_n = 1'b1;
    endtask

    task automatic t_timer;
        xfer(1'b0, 1'b0, 24, 1'b0, '0, rx);
        check("R2 before first wrap", rx, {8'd0, frame_of(14'h0)});
        tick(PERIOD + 100);
        xfer(1'b0, 1'b0, 24, 1'b0, '0, rx);
        check("R2 after wrap", rx, {8'd0, frame_of(14'h1234)});
    endtask

    task automatic t_modes;
        logic [13:0] vals [4] = '{14'h2A5C, 14'h1001, 14'h0F0F, 14'h3C3C};
        for (int m = 0; m < 4; m++) begin
            sample_in = vals[m];
            tick(PERIOD + 100);
            xfer(m[1], m[0], 24, 1'b0, '0, rx);
            check("R6 mode frame", rx, {8'd0, frame_of(vals[m])});
            check("R3 filler byte", {24'd0, rx[23:16]}, 32'hFF);
        end
    endtask

    task automatic t_extremes;
        sample_in = 14'h3FFF;
        tick(PERIOD + 100);
        xfer(1'b0, 1'b0, 24, 1'b0, '0, rx);
        check("R4 full scale", rx, {8'd0, 24'hFF3FFF});
        sample_in = 14'h0001;
        tick(PERIOD + 100);
        xfer(1'b1, 1'b1, 24, 1'b0, '0, rx);
        check("R4 lsb only", rx, {8'd0, 24'hFF0001});
    endtask

    task automatic t_snapshot;
        sample_in = 14'h0ABC;
        tick(PERIOD + 100);
        xfer(1'b0, 1'b0, 24, 1'b1, 14'h1555, rx);
        check("R5 word held mid-frame", rx, {8'd0, frame_of(14'h0ABC)});
        xfer(1'b0, 1'b1, 24, 1'b0, '0, rx);
        check("R5 new word next frame", rx, {8'd0, frame_of(14'h1555)});
    endtask

    task automatic t_abort;
        xfer(1'b1, 1'b0, 10, 1'b0, '0, rx);
        check("R7 partial bits", rx, {22'd0, 8'hFF, 2'b00});
        xfer(1'b1, 1'b0, 24, 1'b0, '0, rx);
        check("R7 restart after abort", rx, {8'd0, frame_of(14'h1555)});
    endtask

    task automatic t_tail;
        xfer(1'b0, 1'b0, 32, 1'b0, '0, rx);
        check("R9 frame plus tail", rx, {frame_of(14'h1555), 8'hFF});
    endtask

    initial begin
        t_reset();
        t_timer();
        t_modes();
        t_extremes();
        t_snapshot();
        t_abort();
        t_tail();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule